// File: doc/BRIEF.md
# Wide-to-Narrow Synchronous Bus Cycle Bridge

This block lets a fast 32-bit host processor with an asynchronous strobe-and-acknowledge bus drive a legacy 16-bit motherboard bus. The motherboard logic runs entirely on its own system clock and ends each cycle with a termination signal produced on that clock. The bridge therefore rebuilds every host access as one or two clean, clock-aligned 16-bit cycles. Between any two cycles it always leaves an idle gap, so slow synchronous logic on the motherboard never misses the start of a cycle.

After reset the bridge asks the motherboard's original processor to give up the bus. It keeps the new host in reset until that processor grants the bus. From then on, the host's address strobe, direction, size and address pass through a multi-flop synchronizer into the system-clock domain. A 32-bit access becomes two 16-bit cycles, high word first. A 16-bit or 8-bit access becomes a single cycle whose data strobes follow the size and the low address bit. When the last cycle is done, the bridge acknowledges the host. It holds the acknowledge and the read data until the host drops its strobe.

The host side uses a four-phase strobe handshake instead of valid/ready. This is because the host runs on a clock that is unrelated to the system clock. Back-pressure works through the acknowledge: no new request is accepted until the host has released its strobe and the synchronized copy has fallen.

Top module: `bwb_bridge`

## Requirements
- R1: Bus request output is low during reset, goes high on the first system clock after reset is released, and then stays high. Host reset output is high from reset until the clock edge at which bus grant is sampled high, and is low after that edge.
- R2: No motherboard cycle starts (the address strobe stays low) while host reset is held, even when the host strobe is asserted.
- R3: A long access (size code 00 or 11) runs two cycles with both data strobes. The first cycle uses the host address and carries write data bits 31:16. The second uses address+2 and carries bits 15:0. A long read returns {first word, second word}.
- R4: A word access (size code 10) runs one cycle with both data strobes and write data bits 15:0. A word read returns the word in both halves of the read result.
- R5: A byte access (size code 01) runs one cycle. Address bit 0 = 0 asserts only the upper strobe, and bit 0 = 1 asserts only the lower strobe. Write data bits 7:0 are driven on both byte lanes. A byte read returns the fetched word in both halves.
- R6: Termination is sampled on the rising system clock. The address strobe and both data strobes fall at the edge where termination is sampled high. Data strobes are never high while the address strobe is low, and the address stays stable while the address strobe is high.
- R7: After every cycle, the address strobe stays low for at least one full system clock before the next cycle begins.
- R8: The host strobe passes through SYNC_STAGES flops. When the bridge is idle and granted, the first cycle's address strobe rises on the (SYNC_STAGES+1)-th rising edge after the host strobe is asserted.
- R9: The host acknowledge rises after the last cycle. It stays high, with stable read data, as long as the synchronized host strobe stays high, and no new cycle starts during that time. The acknowledge falls once the strobe has dropped.
- R10: The motherboard direction output is 1 for a read and 0 for a write during every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock of the motherboard |
| rst_ni | input | 1 | Active-low reset |
| mb_busreq_o | output | 1 | Request for the bus from the original processor |
| mb_busgrant_i | input | 1 | Bus granted by the original processor |
| host_rst_o | output | 1 | Holds the host processor in reset |
| host_as_i | input | 1 | Host address strobe (asynchronous) |
| host_rw_i | input | 1 | Host direction, 1 = read |
| host_siz_i | input | 2 | Host size: 01 byte, 10 word, 00/11 long |
| host_addr_i | input | AW | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| host_ack_o | output | 1 | Acknowledge for a 32-bit port to the host |
| host_rdata_o | output | 32 | Assembled read data |
| mb_as_o | output | 1 | Motherboard address strobe |
| mb_uds_o | output | 1 | Upper byte data strobe |
| mb_lds_o | output | 1 | Lower byte data strobe |
| mb_rw_o | output | 1 | Motherboard direction, 1 = read |
| mb_addr_o | output | AW | Motherboard byte address |
| mb_wdata_o | output | 16 | Motherboard write data |
| mb_rdata_i | input | 16 | Motherboard read data |
| mb_term_i | input | 1 | Cycle termination, synchronous to clk_i |

## Verification
The bench builds the bridge with AW = 20 and SYNC_STAGES = 3. The deeper synchronizer moves the start of the first cycle to the fourth rising edge, which catches a synchronizer stage that is lost or skipped. The narrower address checks that address+2 and the address lanes follow the parameter. The modelled slave answers after one, two or three system clocks, so back-to-back long halves are tested with both the shortest and a stretched cycle.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  typedef enum logic [1:0] {
    K_BYTE,
    K_WORD,
    K_LONG
  } xfer_kind_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ACT,
    ENG_GAP
  } eng_state_e;

  typedef enum logic [2:0] {
    SEQ_GRAB,
    SEQ_READY,
    SEQ_FIRST,
    SEQ_SECOND,
    SEQ_ACK
  } seq_state_e;

  function automatic xfer_kind_e size_to_kind(input logic [1:0] siz);
    case (siz)
      2'b01:   return K_BYTE;
      2'b10:   return K_WORD;
      default: return K_LONG;
    endcase
  endfunction

endpackage

// File: rtl/bwb_sync.sv
module bwb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q_r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= '0;
        else         q_r <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= '0;
        else         q_r <= g_stage[g-1].q_r;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/bwb_cycle_engine.sv
module bwb_cycle_engine
  import bwb_pkg::*;
#(
  parameter int AW = 24,
  parameter int MW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          uds_i,
  input  logic          lds_i,
  input  logic [MW-1:0] wdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [MW-1:0] rdata_o,
  output logic          mb_as_o,
  output logic          mb_uds_o,
  output logic          mb_lds_o,
  output logic          mb_rw_o,
  output logic [AW-1:0] mb_addr_o,
  output logic [MW-1:0] mb_wdata_o,
  input  logic [MW-1:0] mb_rdata_i,
  input  logic          mb_term_i
);

  eng_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic          rd_q, uds_q, lds_q;
  logic [MW-1:0] wdata_q, rdata_q;

  // A cycle may start from idle or from the one-clock gap state, never from
  // the active state, so the strobe is always low for a full clock between.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      addr_q  <= '0;
      rd_q    <= 1'b1;
      uds_q   <= 1'b0;
      lds_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ENG_IDLE, ENG_GAP: begin
          if (start_i) begin
            state_q <= ENG_ACT;
            addr_q  <= addr_i;
            rd_q    <= rd_i;
            uds_q   <= uds_i;
            lds_q   <= lds_i;
            wdata_q <= wdata_i;
          end else begin
            state_q <= ENG_IDLE;
          end
        end
        ENG_ACT: begin
          if (mb_term_i) begin
            rdata_q <= mb_rdata_i;
            state_q <= ENG_GAP;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign ready_o    = (state_q != ENG_ACT);
  assign done_o     = (state_q == ENG_GAP);
  assign rdata_o    = rdata_q;
  assign mb_as_o    = (state_q == ENG_ACT);
  assign mb_uds_o   = mb_as_o & uds_q;
  assign mb_lds_o   = mb_as_o & lds_q;
  assign mb_rw_o    = rd_q;
  assign mb_addr_o  = addr_q;
  assign mb_wdata_o = wdata_q;

  AST_TERM_ENDS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_as_o && mb_term_i) |=> !mb_as_o); // R6
  AST_GAP_BEFORE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_as_o && mb_term_i) |=> (!mb_as_o && !mb_uds_o && !mb_lds_o)); // R7
  AST_STROBES_NEED_AS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_uds_o || mb_lds_o) |-> mb_as_o); // R6
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_as_o && $past(mb_as_o)) |-> ($stable(mb_addr_o) && $stable(mb_rw_o))); // R6

endmodule

// File: rtl/bwb_sequencer.sv
module bwb_sequencer
  import bwb_pkg::*;
#(
  parameter int AW = 24,
  parameter int HW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grant_i,
  input  logic          req_i,
  input  logic          rd_i,
  input  logic [1:0]    siz_i,
  input  logic [AW-1:0] addr_i,
  input  logic [HW-1:0] wdata_i,
  input  logic          eng_ready_i,
  input  logic          eng_done_i,
  input  logic [HW/2-1:0] eng_rdata_i,
  output logic          start_o,
  output logic [AW-1:0] eng_addr_o,
  output logic          eng_rd_o,
  output logic          eng_uds_o,
  output logic          eng_lds_o,
  output logic [HW/2-1:0] eng_wdata_o,
  output logic          busreq_o,
  output logic          host_rst_o,
  output logic          ack_o,
  output logic [HW-1:0] rdata_o
);

  localparam int MW = HW / 2;

  seq_state_e    state_q;
  xfer_kind_e    kind_q, cur_kind;
  logic [AW-1:0] addr_q, cur_addr;
  logic          rd_q, cur_rd;
  logic [HW-1:0] wdata_q, cur_wdata;
  logic [HW-1:0] rdata_q;
  logic          busreq_q;
  logic          in_ready;

  assign in_ready = (state_q == SEQ_READY);

  // In the ready state the first half is built straight from the
  // synchronized request so that it launches on the next edge.
  always_comb begin
    cur_kind  = in_ready ? size_to_kind(siz_i) : kind_q;
    cur_addr  = in_ready ? addr_i : addr_q + AW'(2);
    cur_rd    = in_ready ? rd_i : rd_q;
    cur_wdata = in_ready ? wdata_i : wdata_q;
    case (cur_kind)
      K_BYTE: begin
        eng_uds_o   = ~cur_addr[0];
        eng_lds_o   = cur_addr[0];
        eng_wdata_o = {cur_wdata[7:0], cur_wdata[7:0]};
      end
      K_WORD: begin
        eng_uds_o   = 1'b1;
        eng_lds_o   = 1'b1;
        eng_wdata_o = cur_wdata[MW-1:0];
      end
      default: begin
        eng_uds_o   = 1'b1;
        eng_lds_o   = 1'b1;
        eng_wdata_o = in_ready ? cur_wdata[HW-1:MW] : cur_wdata[MW-1:0];
      end
    endcase
  end

  assign eng_addr_o = cur_addr;
  assign eng_rd_o   = cur_rd;
  assign start_o    = (in_ready && req_i && eng_ready_i) ||
                      (state_q == SEQ_FIRST && eng_done_i && kind_q == K_LONG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_GRAB;
      kind_q   <= K_LONG;
      addr_q   <= '0;
      rd_q     <= 1'b1;
      wdata_q  <= '0;
      rdata_q  <= '0;
      busreq_q <= 1'b0;
    end else begin
      busreq_q <= 1'b1;
      case (state_q)
        SEQ_GRAB: begin
          if (grant_i) state_q <= SEQ_READY;
        end
        SEQ_READY: begin
          if (start_o) begin
            kind_q  <= cur_kind;
            addr_q  <= addr_i;
            rd_q    <= rd_i;
            wdata_q <= wdata_i;
            state_q <= SEQ_FIRST;
          end
        end
        SEQ_FIRST: begin
          if (eng_done_i) begin
            if (kind_q == K_LONG) begin
              rdata_q[HW-1:MW] <= eng_rdata_i;
              state_q          <= SEQ_SECOND;
            end else begin
              rdata_q <= {eng_rdata_i, eng_rdata_i};
              state_q <= SEQ_ACK;
            end
          end
        end
        SEQ_SECOND: begin
          if (eng_done_i) begin
            rdata_q[MW-1:0] <= eng_rdata_i;
            state_q         <= SEQ_ACK;
          end
        end
        SEQ_ACK: begin
          if (!req_i) state_q <= SEQ_READY;
        end
        default: state_q <= SEQ_GRAB;
      endcase
    end
  end

  assign busreq_o   = busreq_q;
  assign host_rst_o = (state_q == SEQ_GRAB);
  assign ack_o      = (state_q == SEQ_ACK);
  assign rdata_o    = rdata_q;

  AST_NO_CYCLE_IN_GRAB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rst_o |-> !start_o); // R2
  AST_RESET_UNTIL_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rst_o && !grant_i) |=> host_rst_o); // R1
  AST_BUSREQ_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busreq_o) |-> busreq_o); // R1
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_i) |=> ack_o); // R9
  AST_ACK_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(ack_o)) |-> $stable(rdata_o)); // R9
  AST_NO_START_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !start_o); // R9

endmodule

// File: rtl/bwb_bridge.sv
module bwb_bridge
  import bwb_pkg::*;
#(
  parameter int AW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          mb_busreq_o,
  input  logic          mb_busgrant_i,
  output logic          host_rst_o,
  input  logic          host_as_i,
  input  logic          host_rw_i,
  input  logic [1:0]    host_siz_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [31:0]   host_wdata_i,
  output logic          host_ack_o,
  output logic [31:0]   host_rdata_o,
  output logic          mb_as_o,
  output logic          mb_uds_o,
  output logic          mb_lds_o,
  output logic          mb_rw_o,
  output logic [AW-1:0] mb_addr_o,
  output logic [15:0]   mb_wdata_o,
  input  logic [15:0]   mb_rdata_i,
  input  logic          mb_term_i
);

  localparam int HW = 32;
  localparam int MW = HW / 2;
  localparam int SW = AW + 4;

  logic [SW-1:0]  sync_q;
  logic           req_s, rw_s;
  logic [1:0]     siz_s;
  logic [AW-1:0]  addr_s;

  logic           start, eng_ready, eng_done;
  logic [AW-1:0]  eng_addr;
  logic           eng_rd, eng_uds, eng_lds;
  logic [MW-1:0]  eng_wdata, eng_rdata;

  // Strobe, direction, size and address cross together; the host keeps the
  // qualifiers stable before its strobe, so all bits settle in step.
  bwb_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_as_i, host_rw_i, host_siz_i, host_addr_i}),
    .q_o   (sync_q)
  );

  assign {req_s, rw_s, siz_s, addr_s} = sync_q;

  bwb_sequencer #(.AW(AW), .HW(HW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (mb_busgrant_i),
    .req_i      (req_s),
    .rd_i       (rw_s),
    .siz_i      (siz_s),
    .addr_i     (addr_s),
    .wdata_i    (host_wdata_i),
    .eng_ready_i(eng_ready),
    .eng_done_i (eng_done),
    .eng_rdata_i(eng_rdata),
    .start_o    (start),
    .eng_addr_o (eng_addr),
    .eng_rd_o   (eng_rd),
    .eng_uds_o  (eng_uds),
    .eng_lds_o  (eng_lds),
    .eng_wdata_o(eng_wdata),
    .busreq_o   (mb_busreq_o),
    .host_rst_o (host_rst_o),
    .ack_o      (host_ack_o),
    .rdata_o    (host_rdata_o)
  );

  bwb_cycle_engine #(.AW(AW), .MW(MW)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .addr_i    (eng_addr),
    .rd_i      (eng_rd),
    .uds_i     (eng_uds),
    .lds_i     (eng_lds),
    .wdata_i   (eng_wdata),
    .ready_o   (eng_ready),
    .done_o    (eng_done),
    .rdata_o   (eng_rdata),
    .mb_as_o   (mb_as_o),
    .mb_uds_o  (mb_uds_o),
    .mb_lds_o  (mb_lds_o),
    .mb_rw_o   (mb_rw_o),
    .mb_addr_o (mb_addr_o),
    .mb_wdata_o(mb_wdata_o),
    .mb_rdata_i(mb_rdata_i),
    .mb_term_i (mb_term_i)
  );

  AST_NO_BUS_BEFORE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rst_o |-> !mb_as_o); // R2
  AST_ACK_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_ack_o && $past(host_ack_o)) |-> !mb_as_o); // R9

endmodule

// File: tb/tb_bwb_bridge.sv
`timescale 1ns/1ps
module tb_bwb_bridge;

  localparam int CLK_PERIOD = 125;
  localparam int AW         = 20;
  localparam int SYNC       = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mb_busreq, mb_busgrant = 1'b0, host_rst;
  logic          host_as = 1'b0, host_rw = 1'b1;
  logic [1:0]    host_siz = 2'b00;
  logic [AW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic          host_ack;
  logic [31:0]   host_rdata;
  logic          mb_as, mb_uds, mb_lds, mb_rw;
  logic [AW-1:0] mb_addr;
  logic [15:0]   mb_wdata;
  logic [15:0]   mb_rdata = '0;
  logic          mb_term = 1'b0;

  bwb_bridge #(.AW(AW), .SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mb_busreq_o(mb_busreq), .mb_busgrant_i(mb_busgrant), .host_rst_o(host_rst),
    .host_as_i(host_as), .host_rw_i(host_rw), .host_siz_i(host_siz),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_ack_o(host_ack), .host_rdata_o(host_rdata),
    .mb_as_o(mb_as), .mb_uds_o(mb_uds), .mb_lds_o(mb_lds), .mb_rw_o(mb_rw),
    .mb_addr_o(mb_addr), .mb_wdata_o(mb_wdata), .mb_rdata_i(mb_rdata), .mb_term_i(mb_term)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int       addr;
    bit       uds;
    bit       lds;
    bit       rd;
    int       wd;
    string    req;
  } cyc_t;

  cyc_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  int   cyc_n = 0;
  int   n_cycles = 0;
  int   lat = 1;
  int   wait_cnt = 0, low_cnt = 1;
  bit   as_seen = 0, term_prev = 0;
  int   cur_addr = 0;
  int   base_cycles = 0, first_cyc = 0;
  bit   finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word_at(input int a);
    int w;
    w = (a & ~1) & ((1 << AW) - 1);
    return 16'(((w >> 1) * 16'h1357) ^ 16'hA5C3);
  endfunction

  always @(posedge clk) cyc_n <= cyc_n + 1;

  // Synchronous slave: responds lat clocks after seeing the strobe and checks
  // every cycle start against the expected list.
  always @(negedge clk) begin
    if (rst_n) begin
      if ((mb_uds || mb_lds) && !mb_as) chk("R6 data strobe without address strobe", 1, 0);
      if (host_rst && mb_as) chk("R2 cycle while host in reset", 1, 0);
      if (term_prev && mb_as) chk("R6 strobe kept after termination", 1, 0);
      if (mb_as) begin
        if (!as_seen) begin
          as_seen = 1;
          wait_cnt = 0;
          cur_addr = int'(mb_addr);
          if (n_cycles == base_cycles) first_cyc = cyc_n;
          n_cycles++;
          chk("R7 idle clock before cycle", (low_cnt >= 1), 1);
          if (exp_q.size() == 0) chk("R3 unexpected cycle", 1, 0);
          else begin
            cyc_t e;
            e = exp_q.pop_front();
            chk({e.req, " address"}, 32'(mb_addr), 32'(e.addr & ((1 << AW) - 1)));
            chk({e.req, " upper strobe"}, 32'(mb_uds), 32'(e.uds));
            chk({e.req, " lower strobe"}, 32'(mb_lds), 32'(e.lds));
            chk("R10 direction", 32'(mb_rw), 32'(e.rd));
            if (!e.rd) chk({e.req, " write data"}, 32'(mb_wdata), 32'(e.wd & 16'hFFFF));
          end
        end else begin
          chk("R6 address stable", 32'(mb_addr), 32'(cur_addr));
        end
        wait_cnt++;
        if (wait_cnt >= lat) begin
          mb_term  <= 1'b1;
          mb_rdata <= word_at(int'(mb_addr));
          term_prev = 1;
        end else term_prev = 0;
      end else begin
        if (as_seen) begin as_seen = 0; low_cnt = 0; end
        low_cnt++;
        mb_term  <= 1'b0;
        term_prev = 0;
      end
    end
  end

  task automatic access(input bit rd, input logic [1:0] siz, input int addr,
                        input logic [31:0] wd, input int latency);
    string tag;
    logic [31:0] exp_rd;
    int ncyc, t0, waited;
    lat = latency;
    if (siz == 2'b01) begin
      tag = "R5";
      exp_q.push_back('{addr, !addr[0], addr[0], rd, int'({wd[7:0], wd[7:0]}), tag});
      exp_rd = {word_at(addr), word_at(addr)};
      ncyc = 1;
    end else if (siz == 2'b10) begin
      tag = "R4";
      exp_q.push_back('{addr, 1, 1, rd, int'(wd[15:0]), tag});
      exp_rd = {word_at(addr), word_at(addr)};
      ncyc = 1;
    end else begin
      tag = "R3";
      exp_q.push_back('{addr, 1, 1, rd, int'(wd[31:16]), tag});
      exp_q.push_back('{addr + 2, 1, 1, rd, int'(wd[15:0]), tag});
      exp_rd = {word_at(addr), word_at(addr + 2)};
      ncyc = 2;
    end
    @(negedge clk);
    base_cycles = n_cycles;
    host_rw = rd; host_siz = siz; host_addr = AW'(addr); host_wdata = wd;
    host_as = 1'b1;
    t0 = cyc_n;
    waited = 0;
    while (!host_ack && waited < 400) begin @(negedge clk); waited++; end
    chk("R9 acknowledge arrives", 32'(host_ack), 1);
    chk("R8 first cycle start latency", 32'(first_cyc - t0), 32'(SYNC + 1));
    if (rd) chk({tag, " read data"}, host_rdata, exp_rd);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 acknowledge held", 32'(host_ack), 1);
      if (rd) chk("R9 read data held", host_rdata, exp_rd);
    end
    chk("R9 no cycle while acknowledged", 32'(n_cycles - base_cycles), 32'(ncyc));
    host_as = 1'b0;
    waited = 0;
    while (host_ack && waited < 50) begin @(negedge clk); waited++; end
    chk("R9 acknowledge released", 32'(host_ack), 0);
    chk({tag, " all cycles seen"}, 32'(exp_q.size()), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 no bus request in reset", 32'(mb_busreq), 0);
    chk("R1 host reset held in reset", 32'(host_rst), 1);
    chk("R2 no strobe in reset", 32'(mb_as), 0);
    chk("R9 no acknowledge in reset", 32'(host_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus request after reset", 32'(mb_busreq), 1);
    // R2: host strobe during the grab phase must not start a cycle
    host_as = 1'b1; host_rw = 1'b1; host_siz = 2'b00; host_addr = '0;
    repeat (10) @(negedge clk);
    chk("R2 no cycle before grant", 32'(n_cycles), 0);
    chk("R1 host held before grant", 32'(host_rst), 1);
    host_as = 1'b0;
    repeat (SYNC + 3) @(negedge clk);
    mb_busgrant = 1'b1;
    @(negedge clk);
    chk("R1 host released after grant", 32'(host_rst), 0);
    chk("R1 bus request kept", 32'(mb_busreq), 1);
    repeat (2) @(negedge clk);

    access(1, 2'b00, 'h0, 32'h0, 1);          // R3 vector fetch, fast slave
    access(1, 2'b00, 'h4, 32'h0, 3);          // R3 stretched cycles
    access(0, 2'b00, 'h100, 32'hDEADBEEF, 2); // R3 R10 long write
    access(1, 2'b11, 'h3F8, 32'h0, 1);        // R3 size code 11
    access(1, 2'b10, 'h202, 32'h0, 2);        // R4 word read
    access(0, 2'b10, 'h204, 32'h1234ABCD, 1); // R4 word write
    access(1, 2'b01, 'h301, 32'h0, 1);        // R5 lower lane
    access(1, 2'b01, 'h300, 32'h0, 3);        // R5 upper lane
    access(0, 2'b01, 'h305, 32'h0000007E, 2); // R5 byte write
    access(1, 2'b00, 'hFFFFC, 32'h0, 2);      // R3 top of address space

    chk("R1 bus request kept to end", 32'(mb_busreq), 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule